// File: doc/BRIEF.md
# Seat Belt Reminder Controller

This block watches two occupant sensors, one for a person in the seat and one for a fastened buckle. It decides when an audible reminder is due. A person sitting down starts a reminder countdown. If the countdown runs out while the buckle is still open, the buzzer turns on. The buzzer stays on until the buckle closes or the seat empties. Opening the buckle again while seated starts the countdown over with its full length.

The sensors are plain level inputs and are assumed to be already clean and synchronous to the clock. The block has no data stream, so it has no valid/ready interface. All pins are plain control and status lines.

The outputs are:
- a registered buzzer line,
- a flag that is high while the countdown runs,
- the current state on a two-bit code.

The countdown length is set by the parameter `TIMEOUT_CYCLES`.

Top module: `belt_reminder_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block enters state code 0 after that edge, with `buzzer_o` low and `timer_run_o` low.
- R2: `state_o` shows the state with this encoding: 0 = idle, 1 = seated (waiting for buckle), 2 = belted, 3 = buzzing.
- R3: In idle, `seat_i` high moves the block to code 1 at the next edge and starts the countdown, so `timer_run_o` is high after that edge. With `seat_i` low the block stays in idle.
- R4: The countdown expires `TIMEOUT_CYCLES` edges after the edge that started it, and `timer_run_o` falls at that same edge. If the block is still in code 1 with the seat occupied and the buckle open, it moves to code 3 on the following edge. That is `TIMEOUT_CYCLES`+1 edges after the start.
- R5: In code 1, an occupied seat with the buckle closed moves the block to code 2 at the next edge. This holds even when the countdown expires in that same cycle, because buckling wins over expiry.
- R6: In code 3, the block stays in code 3 while the seat is occupied and the buckle is open. Closing the buckle moves it to code 2 and turns the buzzer off at the next edge.
- R7: In code 2, opening the buckle with the seat occupied moves the block to code 1 and reloads the countdown with its full length.
- R8: From any state, `seat_i` low moves the block to code 0 at the next edge and stops the countdown. This takes priority over any buckle change in the same cycle.
- R9: `buzzer_o` is a register output that is high exactly while `state_o` is 3.
- R10: A countdown expiry while in code 2 has no effect. The block stays in code 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| seat_i | input | 1 | High while the seat is occupied |
| belt_i | input | 1 | High while the buckle is fastened |
| buzzer_o | output | 1 | Registered buzzer drive |
| timer_run_o | output | 1 | High while the reminder countdown is running |
| state_o | output | 2 | Current state code (0 idle, 1 seated, 2 belted, 3 buzzing) |

## Verification
Two pairs of events can land in the same cycle:
- Countdown expiry and buckling. The bench provokes this by closing the buckle exactly in the cycle where the expiry flag is raised. The block must then settle in belted and never buzz.
- Leaving the seat and closing the buckle. The bench changes both inputs together, and the block must go to idle with the countdown stopped.

A behavioural reference model, written in terms of remaining cycles, is compared with the outputs on every clock. Targeted checks are also made at the cycle counts that R4 and R7 predict.

// File: rtl/brc_pkg.sv
`timescale 1ns/1ps
package brc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEATED = 2'd1,
    ST_BELTED = 2'd2,
    ST_BUZZ   = 2'd3
  } brc_state_e;
endpackage

// File: rtl/brc_timer.sv
`timescale 1ns/1ps
// Reminder down-counter: load on start, raise a one-cycle expiry when it runs out.
module brc_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic clear_i,
  output logic run_o,
  output logic expire_o
);
  localparam int unsigned CNT_W = (TIMEOUT_CYCLES < 2) ? 1 : $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TIMEOUT_CYCLES);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             exp_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= LOAD_VAL;
      run_q <= 1'b1;
      exp_q <= 1'b0;
    end else if (run_q && (cnt_q == LAST_VAL)) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b1;
    end else if (run_q) begin
      cnt_q <= cnt_q - LAST_VAL;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
    end
  end

  assign run_o    = run_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/brc_fsm.sv
`timescale 1ns/1ps
// Four-state sequencer; seat absence overrides everything else.
module brc_fsm
  import brc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       seat_i,
  input  logic       belt_i,
  input  logic       expire_i,
  output brc_state_e state_o,
  output brc_state_e next_o,
  output logic       tmr_start_o,
  output logic       tmr_clear_o
);
  brc_state_e cur_q, nxt;
  logic       start;

  always_comb begin
    nxt   = cur_q;
    start = 1'b0;
    if (!seat_i) begin
      nxt = ST_IDLE;
    end else begin
      case (cur_q)
        ST_IDLE: begin
          nxt   = ST_SEATED;
          start = 1'b1;
        end
        ST_SEATED: begin
          if (belt_i)        nxt = ST_BELTED;
          else if (expire_i) nxt = ST_BUZZ;
        end
        ST_BELTED: begin
          if (!belt_i) begin
            nxt   = ST_SEATED;
            start = 1'b1;
          end
        end
        ST_BUZZ: begin
          if (belt_i) nxt = ST_BELTED;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= ST_IDLE;
    else     cur_q <= nxt;
  end

  assign state_o     = cur_q;
  assign next_o      = nxt;
  assign tmr_start_o = start;
  assign tmr_clear_o = (nxt == ST_IDLE);
endmodule

// File: rtl/belt_reminder_ctrl.sv
`timescale 1ns/1ps
module belt_reminder_ctrl
  import brc_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       seat_i,
  input  logic       belt_i,
  output logic       buzzer_o,
  output logic       timer_run_o,
  output logic [1:0] state_o
);
  brc_state_e cur_st, nxt_st;
  logic       tmr_start, tmr_clear, tmr_expire, tmr_run;
  logic       buzz_q;

  brc_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .seat_i     (seat_i),
    .belt_i     (belt_i),
    .expire_i   (tmr_expire),
    .state_o    (cur_st),
    .next_o     (nxt_st),
    .tmr_start_o(tmr_start),
    .tmr_clear_o(tmr_clear)
  );

  brc_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start_i (tmr_start),
    .clear_i (tmr_clear),
    .run_o   (tmr_run),
    .expire_o(tmr_expire)
  );

  // Buzzer register follows the state entered at the same edge.
  always_ff @(posedge clk) begin
    if (rst) buzz_q <= 1'b0;
    else     buzz_q <= (nxt_st == ST_BUZZ);
  end

  assign buzzer_o    = buzz_q;
  assign timer_run_o = tmr_run;
  assign state_o     = cur_st;
endmodule

// File: rtl/brc_checker.sv
`timescale 1ns/1ps
module brc_checker (
  input logic       clk,
  input logic       rst,
  input logic       seat_i,
  input logic       belt_i,
  input logic       buzzer_o,
  input logic       timer_run_o,
  input logic [1:0] state_o
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (state_o == 2'd0 && !buzzer_o && !timer_run_o));

  p_buzz_tracks_state_r9: assert property (@(posedge clk) disable iff (rst)
    buzzer_o == (state_o == 2'd3));

  p_idle_seat_r3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0 && seat_i) |=> (state_o == 2'd1 && timer_run_o));

  p_idle_stay_r3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0 && !seat_i) |=> (state_o == 2'd0));

  p_buckle_r5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1 && seat_i && belt_i) |=> (state_o == 2'd2));

  p_buzz_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd3 && seat_i && !belt_i) |=> (state_o == 2'd3));

  p_buzz_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd3 && seat_i && belt_i) |=> (state_o == 2'd2 && !buzzer_o));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2 && seat_i && !belt_i) |=> (state_o == 2'd1 && timer_run_o));

  p_empty_seat_r8: assert property (@(posedge clk) disable iff (rst)
    !seat_i |=> (state_o == 2'd0 && !timer_run_o));

  p_belted_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2 && seat_i && belt_i) |=> (state_o == 2'd2));
endmodule

bind belt_reminder_ctrl brc_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .seat_i     (seat_i),
  .belt_i     (belt_i),
  .buzzer_o   (buzzer_o),
  .timer_run_o(timer_run_o),
  .state_o    (state_o)
);

// File: tb/belt_reminder_ctrl_tb.sv
`timescale 1ns/1ps
module belt_reminder_ctrl_tb;
  localparam int T = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       seat = 1'b0;
  logic       belt = 1'b0;
  logic       buzz, trun;
  logic [1:0] st;

  int  checks = 0;
  int  fails  = 0;
  bit  cmp_en = 1'b0;
  bit  done   = 1'b0;

  // Reference model state
  int  m_st  = 0;
  int  m_cnt = 0;
  bit  m_run = 1'b0;
  bit  m_exp = 1'b0;

  always #2.5 clk = ~clk;

  belt_reminder_ctrl #(.TIMEOUT_CYCLES(T)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .seat_i     (seat),
    .belt_i     (belt),
    .buzzer_o   (buzz),
    .timer_run_o(trun),
    .state_o    (st)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural reference: remaining-cycle count and a pending expiry.
  always @(posedge clk) begin
    int  nst;
    bit  go;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_run = 0; m_exp = 0;
    end else begin
      go  = 1'b0;
      nst = m_st;
      if (!seat) nst = 0;
      else if (m_st == 0) begin nst = 1; go = 1'b1; end
      else if (m_st == 1) begin
        if (belt) nst = 2;
        else if (m_exp) nst = 3;
      end
      else if (m_st == 2) begin
        if (!belt) begin nst = 1; go = 1'b1; end
      end
      else if (belt) nst = 2;
      if (nst == 0) begin
        m_cnt = 0; m_run = 0; m_exp = 0;
      end else if (go) begin
        m_cnt = T; m_run = 1; m_exp = 0;
      end else if (m_run && m_cnt == 1) begin
        m_cnt = 0; m_run = 0; m_exp = 1;
      end else begin
        if (m_run) m_cnt = m_cnt - 1;
        m_exp = 0;
      end
      m_st = nst;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R2 state vs model", int'(st), m_st);
      chk("R9 buzzer vs model", int'(buzz), int'(m_st == 3));
      chk("R4 timer_run vs model", int'(trun), int'(m_run));
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    cmp_en = 1'b1;
    chk("R1 reset state", int'(st), 0);
    chk("R1 reset timer", int'(trun), 0);
    chk("R1 reset buzzer", int'(buzz), 0);

    step(3);
    chk("R3 idle without seat", int'(st), 0);

    seat = 1'b1; step(1);
    chk("R3 seated entry", int'(st), 1);
    chk("R3 timer started", int'(trun), 1);

    step(4); belt = 1'b1; step(1);
    chk("R5 buckle to belted", int'(st), 2);

    step(T + 4);
    chk("R10 expiry ignored in belted", int'(st), 2);

    belt = 1'b0; step(1);
    chk("R7 release to seated", int'(st), 1);
    chk("R7 timer reloaded", int'(trun), 1);
    step(T);
    chk("R7 full reload, still seated", int'(st), 1);
    step(1);
    chk("R4 buzzer state after timeout", int'(st), 3);
    chk("R6 buzzer on", int'(buzz), 1);

    step(5);
    chk("R6 buzzer held", int'(st), 3);

    belt = 1'b1; step(1);
    chk("R6 buckle clears buzzer state", int'(st), 2);
    chk("R6 buzzer off", int'(buzz), 0);

    belt = 1'b0; step(1);
    seat = 1'b0; belt = 1'b1; step(1);
    chk("R8 seat leave beats buckle", int'(st), 0);
    chk("R8 timer stopped", int'(trun), 0);

    // Expiry and buckling in the same cycle
    belt = 1'b0; seat = 1'b1; step(1);
    step(T);
    belt = 1'b1; step(1);
    chk("R5 buckle wins over expiry", int'(st), 2);
    chk("R5 no buzzer", int'(buzz), 0);

    belt = 1'b0; step(1);
    step(T + 1);
    chk("R4 buzzer after reload", int'(st), 3);
    seat = 1'b0; belt = 1'b1; step(1);
    chk("R8 empty seat from buzzer", int'(st), 0);
    chk("R8 buzzer off", int'(buzz), 0);

    seat = 1'b1; belt = 1'b0; step(3);
    rst = 1'b1; step(1);
    chk("R1 mid-run reset state", int'(st), 0);
    chk("R1 mid-run reset timer", int'(trun), 0);
    rst = 1'b0; seat = 1'b0; step(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule